// File: doc/BRIEF.md
# Collision Jam and Backoff Controller

This block sequences the retries of one outgoing frame on a half-duplex 10 Mb/s link. A neighbouring serializer sends the frame bits and a line interface reports collisions. Both share a strobe that pulses once per bit time. When a frame is requested, the controller grants transmit permission. If a collision is seen while permission is held, it withdraws permission and drives a fixed-length jam. It then waits a random whole number of slot times and grants permission again. If the serializer reports the last bit with no collision, the controller signals success.

The random wait after the k-th collision of a frame is drawn from a free-running 16-bit linear feedback shift register. The low bits of that register are masked to k bits and the result is incremented, so the draw lies in 1 to 2^k slots. The exponent stops growing at a parameterised cap. The frame is abandoned with a one-cycle error pulse in two cases: when the attempt limit is used up, or when single-attempt mode is on and the attempt collides. For testing, a forced-collision control makes every attempt collide, but only while internal loopback is selected.

Top module: `coll_backoff_ctrl`

## Requirements
- R1: A collision seen while `tx_go` is high makes `jam_en` rise on the next clock and stay high for exactly JAM_BITS bit ticks. `tx_go` is low during the jam.
- R2: When a jam ends and the frame is not abandoned, both outputs stay low for a whole number of slots, each SLOT_BITS bit ticks long. `tx_go` then rises again.
- R3: After the n-th collision of a frame, the number of backoff slots lies in 1 to 2^min(n, K_CAP). Over many draws at the cap, both the smallest value (1) and the largest value (2^K_CAP) occur.
- R4: A collision is handled the same way whatever cycle of the attempt it arrives in.
- R5: After MAX_ATTEMPTS attempts have all collided, no further attempt is made. `retry_err` pulses for one cycle in the cycle after the last jam ends.
- R6: `tx_end` while `tx_go` is high, with no collision in that cycle, gives a one-cycle `tx_done` pulse. It also clears the collision count, so the next frame starts again at n = 1.
- R7: With `retry_dis` high, a frame gets a single attempt. A collision on that attempt is followed by the jam and then `retry_err`, with no backoff.
- R8: With `int_loop` and `force_col` both high, every attempt collides in its first cycle. The frame ends in `retry_err` after MAX_ATTEMPTS attempts, or after one attempt if `retry_dis` is high.
- R9: `force_col` has no effect while `int_loop` is low, and `int_loop` alone has no effect. In both cases a frame without line collisions succeeds on its first attempt.
- R10: The jam and backoff counts advance only in cycles where `bit_tick` is high. With `bit_tick` held low, `jam_en` stays high.
- R11: While `rst_n` is low, `jam_en`, `tx_go`, `tx_done` and `retry_err` are all low.
- R12: If `col_det` and `tx_end` arrive in the same cycle, the collision wins. No `tx_done` is given and the attempt is jammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe, once per bit time |
| tx_req | input | 1 | Frame waiting to be sent; held until `tx_done` or `retry_err` |
| tx_end | input | 1 | Serializer has sent the last bit of the attempt |
| col_det | input | 1 | Collision reported by the line interface |
| retry_dis | input | 1 | Single-attempt mode |
| int_loop | input | 1 | Internal loopback selected |
| force_col | input | 1 | Test control that injects a collision on each attempt |
| jam_en | output | 1 | Drive the jam pattern |
| tx_go | output | 1 | Permission to transmit the frame |
| tx_done | output | 1 | One-cycle pulse on success |
| retry_err | output | 1 | One-cycle pulse when the frame is abandoned |

## Verification
The assertions take the following for granted about the inputs:
- `tx_req` is dropped in the cycle that `tx_done` or `retry_err` appears.
- `tx_end` and `col_det` are only meaningful while `tx_go` is high.
- `bit_tick` is a plain strobe with no other timing relation to the controller.

The bench keeps to these rules. It raises `tx_end` or `col_det` only in cycles where it has seen `tx_go` high, and it clears every control when the frame ends. It draws the collision count, the cycle of the collision within the attempt, the mode bits and same-cycle collision/end cases from a seeded generator. It holds `bit_tick` high except in one directed case that stalls it in the middle of a jam.

// File: rtl/cbk_pkg.sv
// Package: shared state encoding and helpers for the collision backoff controller.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package cbk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_XMIT    = 2'd1,
        ST_JAM     = 2'd2,
        ST_BACKOFF = 2'd3
    } cbk_state_e;

    // Smaller of two unsigned counts, used to cap the backoff exponent.
    function automatic int unsigned cbk_min(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cbk_lfsr.sv
// Module: cbk_lfsr
// Free-running Galois shift register (right-shifting) that supplies the
// random bits for backoff draws. It advances on every clock, whether or not
// a draw is pending.
// Assumes: TAPS gives a maximal-length polynomial for WIDTH, SEED is
// non-zero, and OUT_W <= WIDTH.
module cbk_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0] SEED  = 16'hACE1,
    parameter int               OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);

    logic [WIDTH-1:0] state_q;

    // Step the register once per clock; load the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS;
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign rnd = state_q[OUT_W-1:0];

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R3

endmodule

// File: rtl/cbk_jam_timer.sv
// Module: cbk_jam_timer
// Counts the jam length in bit ticks. A start pulse arms the timer. The
// last output is high in the cycle of the final tick, so the sequencer can
// leave the jam state on that clock edge.
// Assumes: JAM_BITS >= 2, and start is never given while the timer is armed.
module cbk_jam_timer #(
    parameter int JAM_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic last
);

    localparam int CNT_W = $clog2(JAM_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(JAM_BITS - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    assign last = active_q && tick && (cnt_q == CNT_LAST);

    // Arm on start, count ticks while armed, disarm after the final tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (last) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_JAM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !tick && !start) |=> (active_q && $stable(cnt_q))); // R10

    AST_JAM_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q); // R1

endmodule

// File: rtl/cbk_backoff_timer.sv
// Module: cbk_backoff_timer
// Counts down a backoff given in slots, each SLOT_BITS bit ticks long.
// expire is high in the cycle of the final tick of the final slot.
// Assumes: load comes with a non-zero slot count, and SLOT_BITS >= 2.
module cbk_backoff_timer #(
    parameter int SLOT_BITS = 512,
    parameter int SLOTS_W   = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SLOTS_W-1:0] slots_in,
    input  logic               tick,
    output logic               expire
);

    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

    logic               active_q;
    logic [SLOTS_W-1:0] slots_q;
    logic [BIT_W-1:0]   bit_q;
    logic               slot_end;

    assign slot_end = active_q && tick && (bit_q == BIT_LAST);
    assign expire   = slot_end && (slots_q == SLOTS_W'(1));

    // Load the slot count, then step bit and slot counters on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            slots_q  <= '0;
            bit_q    <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            slots_q  <= slots_in;
            bit_q    <= '0;
        end else if (slot_end) begin
            bit_q <= '0;
            if (slots_q == SLOTS_W'(1)) begin
                active_q <= 1'b0;
            end else begin
                slots_q <= slots_q - 1'b1;
            end
        end else if (active_q && tick) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    AST_BO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (slots_in != '0)); // R3

    AST_BO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !tick && !load) |=> ($stable(slots_q) && $stable(bit_q))); // R10

endmodule

// File: rtl/cbk_fsm.sv
// Module: cbk_fsm
// Retry sequencer. It grants transmit permission, turns a collision into a
// jam, counts collided attempts, and chooses after each jam between
// backing off and abandoning the frame. Success and abandon are reported as
// registered one-cycle pulses.
// Assumes: tx_req is dropped in the cycle a pulse appears; the jam and
// backoff timers report their final tick through jam_last and bo_expire.
module cbk_fsm
    import cbk_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 16,
    parameter int ATT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_req,
    input  logic             col_det,
    input  logic             tx_end,
    input  logic             retry_dis,
    input  logic             force_ok,
    input  logic             jam_last,
    input  logic             bo_expire,
    output logic             jam_start,
    output logic             bo_load,
    output logic [ATT_W-1:0] att,
    output logic             jam_en,
    output logic             tx_go,
    output logic             tx_done,
    output logic             retry_err
);

    localparam logic [ATT_W-1:0] ATT_LIMIT = ATT_W'(MAX_ATTEMPTS);

    cbk_state_e       state_q, state_d;
    logic [ATT_W-1:0] att_q, att_d;
    logic             forced_q, forced_d;
    logic             done_q, done_d;
    logic             err_q, err_d;
    logic             coll;

    assign coll = col_det || forced_q;

    // Next-state decision: attempt start, collision, jam end, backoff end.
    always_comb begin
        state_d   = state_q;
        att_d     = att_q;
        forced_d  = forced_q;
        done_d    = 1'b0;
        err_d     = 1'b0;
        jam_start = 1'b0;
        bo_load   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                att_d = '0;
                if (tx_req) begin
                    state_d  = ST_XMIT;
                    forced_d = force_ok;
                end
            end
            ST_XMIT: begin
                if (coll) begin
                    state_d   = ST_JAM;
                    att_d     = att_q + 1'b1;
                    forced_d  = 1'b0;
                    jam_start = 1'b1;
                end else if (tx_end) begin
                    state_d = ST_IDLE;
                    att_d   = '0;
                    done_d  = 1'b1;
                end
            end
            ST_JAM: begin
                if (jam_last) begin
                    if (retry_dis || (att_q == ATT_LIMIT)) begin
                        state_d = ST_IDLE;
                        att_d   = '0;
                        err_d   = 1'b1;
                    end else begin
                        state_d = ST_BACKOFF;
                        bo_load = 1'b1;
                    end
                end
            end
            ST_BACKOFF: begin
                if (bo_expire) begin
                    state_d  = ST_XMIT;
                    forced_d = force_ok;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register the state, attempt count, forced flag and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            att_q    <= '0;
            forced_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            att_q    <= att_d;
            forced_q <= forced_d;
            done_q   <= done_d;
            err_q    <= err_d;
        end
    end

    assign att       = att_q;
    assign jam_en    = (state_q == ST_JAM);
    assign tx_go     = (state_q == ST_XMIT);
    assign tx_done   = done_q;
    assign retry_err = err_q;

    AST_COLL_JAMS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XMIT && col_det) |=> (state_q == ST_JAM && !done_q)); // R12

    AST_ATT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        att_q <= ATT_LIMIT); // R5

    AST_ERR_FROM_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> ($past(state_q) == ST_JAM)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6

    AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JAM && jam_last && retry_dis) |=> err_q); // R7

    AST_FORCED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF && bo_expire && force_ok) |=> ##1 (state_q == ST_JAM)); // R8

endmodule

// File: rtl/coll_backoff_ctrl.sv
// Module: coll_backoff_ctrl (top)
// Collision jam and backoff controller for one transmit channel. It ties
// together the retry sequencer, the jam and backoff timers and the random
// source, and computes the capped backoff draw from the collision count.
// Assumes: bit_tick is a one-cycle strobe; K_CAP <= LFSR_W and K_CAP < 31;
// JAM_BITS and SLOT_BITS are at least 2.
module coll_backoff_ctrl #(
    parameter int                JAM_BITS     = 32,
    parameter int                SLOT_BITS    = 512,
    parameter int                MAX_ATTEMPTS = 16,
    parameter int                K_CAP        = 10,
    parameter int                LFSR_W       = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS    = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED    = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic tx_req,
    input  logic tx_end,
    input  logic col_det,
    input  logic retry_dis,
    input  logic int_loop,
    input  logic force_col,
    output logic jam_en,
    output logic tx_go,
    output logic tx_done,
    output logic retry_err
);

    import cbk_pkg::*;

    localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
    localparam int SLOTS_W = K_CAP + 1;

    logic               force_ok;
    logic               jam_start;
    logic               jam_last;
    logic               bo_load;
    logic               bo_expire;
    logic [ATT_W-1:0]   att;
    logic [K_CAP-1:0]   rnd;
    logic [K_CAP-1:0]   slot_mask;
    logic [SLOTS_W-1:0] slot_cnt;
    int unsigned        k_exp;

    assign force_ok = int_loop && force_col;

    // Capped exponent, k-bit mask and draw in 1 .. 2^k slots.
    always_comb begin
        k_exp     = cbk_min(32'(att), K_CAP);
        slot_mask = K_CAP'((64'd1 << k_exp) - 64'd1);
        slot_cnt  = {1'b0, rnd & slot_mask} + SLOTS_W'(1);
    end

    cbk_lfsr #(
        .WIDTH (LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED),
        .OUT_W (K_CAP)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    cbk_jam_timer #(
        .JAM_BITS (JAM_BITS)
    ) u_jam (
        .clk   (clk),
        .rst_n (rst_n),
        .start (jam_start),
        .tick  (bit_tick),
        .last  (jam_last)
    );

    cbk_backoff_timer #(
        .SLOT_BITS (SLOT_BITS),
        .SLOTS_W   (SLOTS_W)
    ) u_backoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bo_load),
        .slots_in (slot_cnt),
        .tick     (bit_tick),
        .expire   (bo_expire)
    );

    cbk_fsm #(
        .MAX_ATTEMPTS (MAX_ATTEMPTS),
        .ATT_W        (ATT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_req    (tx_req),
        .col_det   (col_det),
        .tx_end    (tx_end),
        .retry_dis (retry_dis),
        .force_ok  (force_ok),
        .jam_last  (jam_last),
        .bo_expire (bo_expire),
        .jam_start (jam_start),
        .bo_load   (bo_load),
        .att       (att),
        .jam_en    (jam_en),
        .tx_go     (tx_go),
        .tx_done   (tx_done),
        .retry_err (retry_err)
    );

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bo_load |-> (32'(slot_cnt) <= (32'd1 << k_exp))); // R3

    AST_JAM_THEN_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        bo_load |-> (jam_en && jam_last)); // R2

    AST_BACKOFF_THEN_GO: assert property (@(posedge clk) disable iff (!rst_n)
        bo_expire |=> tx_go); // R2

    AST_JAM_ON_COLL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && col_det) |=> (jam_en && !tx_go)); // R1

endmodule

// File: tb/sim_coll_backoff_ctrl.sv
// Bench for coll_backoff_ctrl. It uses short jam and slot lengths and a low
// exponent cap so that long retry runs stay short. Frames are driven by a
// task, and a separate monitor measures jam and backoff lengths at the ports.
module sim_coll_backoff_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TB_JAM     = 4;
    localparam int TB_SLOT    = 8;
    localparam int TB_MAX     = 16;
    localparam int TB_KCAP    = 4;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic tx_req = 1'b0;
    logic tx_end = 1'b0;
    logic col_det = 1'b0;
    logic retry_dis = 1'b0;
    logic int_loop = 1'b0;
    logic force_col = 1'b0;
    wire  jam_en, tx_go, tx_done, retry_err;

    int checks = 0;
    int errors = 0;
    int cyc_total = 0;
    bit finished = 1'b0;
    bit mon_en = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coll_backoff_ctrl #(
        .JAM_BITS     (TB_JAM),
        .SLOT_BITS    (TB_SLOT),
        .MAX_ATTEMPTS (TB_MAX),
        .K_CAP        (TB_KCAP)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_req    (tx_req),
        .tx_end    (tx_end),
        .col_det   (col_det),
        .retry_dis (retry_dis),
        .int_loop  (int_loop),
        .force_col (force_col),
        .jam_en    (jam_en),
        .tx_go     (tx_go),
        .tx_done   (tx_done),
        .retry_err (retry_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int max_slots(input int ncol);
        int k;
        k = (ncol > TB_KCAP) ? TB_KCAP : ncol;
        return 1 << k;
    endfunction

    function automatic int exp_attempts(input int n_coll, input bit rd, input bit forced);
        if (forced) return rd ? 1 : TB_MAX;
        if (rd) return 1;
        if (n_coll >= TB_MAX) return TB_MAX;
        return n_coll + 1;
    endfunction

    function automatic bit exp_error(input int n_coll, input bit rd, input bit forced);
        if (forced) return 1'b1;
        if (rd) return (n_coll >= 1);
        return (n_coll >= TB_MAX);
    endfunction

    // Monitor: jam length, backoff length and slot range, from the ports only.
    bit prev_jam = 1'b0;
    bit prev_go = 1'b0;
    bit gap_on = 1'b0;
    int jam_run = 0;
    int gap = 0;
    int ncol = 0;
    bit seen_one = 1'b0;
    bit seen_top = 1'b0;

    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (jam_en && !prev_jam) begin
                chk(prev_go, "R4", "jam follows permit", int'(prev_go), 1);
                ncol++;
                jam_run = 0;
            end
            if (jam_en) jam_run++;
            if (prev_jam && !jam_en) begin
                chk(jam_run == TB_JAM, "R1", "jam length", jam_run, TB_JAM);
                gap_on = 1'b1;
                gap = 0;
            end
            if (retry_err) begin
                chk(prev_jam, "R5", "abandon right after jam", int'(prev_jam), 1);
                gap_on = 1'b0;
                ncol = 0;
            end else if (tx_done) begin
                gap_on = 1'b0;
                ncol = 0;
            end else if (gap_on && !jam_en && !tx_go) begin
                gap++;
            end
            if (gap_on && tx_go && !prev_go) begin
                chk(gap % TB_SLOT == 0, "R2", "backoff in whole slots", gap,
                    (gap / TB_SLOT) * TB_SLOT);
                chk(gap / TB_SLOT >= 1 && gap / TB_SLOT <= max_slots(ncol), "R3",
                    "backoff slot count", gap / TB_SLOT, max_slots(ncol));
                if (ncol >= TB_KCAP && gap / TB_SLOT == 1) seen_one = 1'b1;
                if (ncol >= TB_KCAP && gap / TB_SLOT == max_slots(TB_KCAP)) seen_top = 1'b1;
                gap_on = 1'b0;
            end
            prev_jam = jam_en;
            prev_go = tx_go;
        end
    end

    // Drive one frame to its end and check the outcome and attempt count.
    task automatic run_req(input int n_coll, input bit rd, input bit il, input bit fc,
                           input bit same_end, input string tag);
        int att = 0;
        int wait_n = 0;
        int cyc = 0;
        bit pg = 1'b0;
        bit got_done = 1'b0;
        bit got_err = 1'b0;
        int e_att;
        bit e_err;
        retry_dis = rd;
        int_loop = il;
        force_col = fc;
        tx_req = 1'b1;
        while (!(got_done || got_err) && cyc < 30000) begin
            @(negedge clk);
            cyc++;
            col_det = 1'b0;
            tx_end = 1'b0;
            if (tx_done) begin
                got_done = 1'b1;
            end else if (retry_err) begin
                got_err = 1'b1;
            end else if (tx_go) begin
                if (!pg) begin
                    att++;
                    wait_n = $urandom_range(0, 6);
                end
                if (wait_n == 0) begin
                    if (att <= n_coll) begin
                        col_det = 1'b1;
                        tx_end = same_end;
                    end else begin
                        tx_end = 1'b1;
                    end
                end
                wait_n--;
            end
            pg = tx_go;
        end
        tx_req = 1'b0;
        col_det = 1'b0;
        tx_end = 1'b0;
        retry_dis = 1'b0;
        int_loop = 1'b0;
        force_col = 1'b0;
        e_att = exp_attempts(n_coll, rd, il && fc);
        e_err = exp_error(n_coll, rd, il && fc);
        chk(got_err == e_err && (got_err || got_done), tag, "frame ends in retry error",
            int'(got_err), int'(e_err));
        chk(att == e_att, tag, "attempt count", att, e_att);
        @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > WATCHDOG && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!jam_en, "R11", "jam_en in reset", int'(jam_en), 0);
        chk(!tx_go, "R11", "tx_go in reset", int'(tx_go), 0);
        chk(!tx_done, "R11", "tx_done in reset", int'(tx_done), 0);
        chk(!retry_err, "R11", "retry_err in reset", int'(retry_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        run_req(0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        run_req(3, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        run_req(1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        run_req(16, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        run_req(20, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        run_req(15, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        run_req(1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        run_req(0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        run_req(0, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        run_req(0, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
        run_req(0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        run_req(0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        run_req(2, 1'b0, 1'b0, 1'b0, 1'b1, "R12");

        // R10: stall the bit strobe in the middle of a jam.
        mon_en = 1'b0;
        retry_dis = 1'b1;
        tx_req = 1'b1;
        t = 0;
        while (!tx_go && t < 20) begin
            @(negedge clk);
            t++;
        end
        col_det = 1'b1;
        @(negedge clk);
        col_det = 1'b0;
        tx_req = 1'b0;
        bit_tick = 1'b0;
        repeat (40) @(negedge clk);
        chk(jam_en && !tx_go && !retry_err, "R10", "jam held without ticks", int'(jam_en), 1);
        bit_tick = 1'b1;
        t = 0;
        while (!retry_err && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk(t == TB_JAM, "R10", "ticks to finish jam", t, TB_JAM);
        retry_dis = 1'b0;
        @(negedge clk);
        prev_jam = 1'b0;
        prev_go = 1'b0;
        gap_on = 1'b0;
        ncol = 0;
        mon_en = 1'b1;

        for (int i = 0; i < 40; i++) begin
            int n;
            bit rd, il, fc, se;
            n = $urandom_range(0, 18);
            rd = ($urandom_range(0, 5) == 0);
            il = ($urandom_range(0, 7) == 0);
            fc = ($urandom_range(0, 7) == 0);
            se = ($urandom_range(0, 3) == 0);
            run_req(n, rd, il, fc, se, "R4");
        end

        chk(seen_one, "R3", "smallest draw at cap seen", int'(seen_one), 1);
        chk(seen_top, "R3", "largest draw at cap seen", int'(seen_top), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule